// File: doc/BRIEF.md
# Shared-SRAM Mailbox Register Bridge

This block lets a host reach a bank of peripheral registers that sit on a local bus the host cannot address. The host has only two byte ports. Port 0 holds an index into a small shared SRAM. Port 1 reads or writes the SRAM byte that the index selects. A bridge state machine takes the place of an embedded controller. It polls a mode byte in the SRAM, runs the requested register read or write on the local bus, and acknowledges by putting the mode byte back to idle.

When no request is pending, the bridge copies peripheral state into fixed SRAM slots, one slot per polling round. These are the interrupt identification byte, the receive FIFO status byte and every receive FIFO byte. The host can read them without a round trip. Host and bridge share a single SRAM port. The host always wins that port, and the bridge repeats any access that was refused.

Bridge states:
- `ST_POLL`: reads the mode byte.
- `ST_DECODE`: examines the mode byte. A request goes to `ST_RD_IDX`; anything else goes to `ST_MIRROR`.
- `ST_RD_IDX` then `ST_LAT_IDX`: fetch and latch the register index.
- For a write: `ST_RD_VAL` then `ST_LAT_VAL`, then `ST_BUS_WR`, then `ST_ACK`.
- For a read: `ST_BUS_RD`, then `ST_BUS_WAIT`, then `ST_PUT_VAL`, then `ST_ACK`.
- `ST_ACK`: writes 0 to the mode byte and returns to `ST_POLL`.
- `ST_MIRROR`: writes one mirror slot and returns to `ST_POLL`.

Every state that touches the SRAM stays where it is until the arbiter grants the port.

Top module: `mbox_bridge`

## Requirements
- R1: A host write to port 0 sets the 8-bit index. A host write to port 1 stores the byte at SRAM[index]. A host read asserts `host_rvalid` for exactly the following cycle. In that cycle `host_rdata` carries the index (port 0) or SRAM[index] (port 1).
- R2: A write request works as follows. The host stores the register index at 0x1B and the value at 0x1C, then writes mode byte 0x1A = 1. The bridge issues one `reg_wr` pulse with that address and data, then sets 0x1A to 0.
- R3: A read request works as follows. The host stores the index at 0x1B and writes 0x1A = 2. The bridge issues one `reg_rd` pulse and samples `reg_rdata` one cycle after it. The bridge stores that value at 0x1C, and only then sets 0x1A to 0.
- R4: A mode byte other than 0, 1 or 2 causes no local bus strobe and is left unchanged.
- R5: SRAM 0x1E mirrors `irq_ident` and SRAM 0x1F mirrors `rx_status`. Both refresh within one full mirror rotation.
- R6: SRAM 0x20+k mirrors receive FIFO byte k, where byte k is `rx_fifo_bytes[8k+7:8k]`.
- R7: A host access is never delayed. If the host uses the SRAM on every cycle, a pending request still completes correctly once the host stops, and no host data is lost.
- R8: After reset the SRAM is all zero, the index is 0, and `host_rvalid`, `reg_wr` and `reg_rd` are low.
- R9: `reg_wr` and `reg_rd` are never high together, and each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| reg_wr | output | 1 | Local register write pulse |
| reg_rd | output | 1 | Local register read pulse |
| reg_addr | output | 8 | Local register index |
| reg_wdata | output | 8 | Local register write data |
| reg_rdata | input | 8 | Local register read data, one cycle after reg_rd |
| irq_ident | input | 8 | Interrupt identification to mirror |
| rx_status | input | 8 | Receive FIFO status to mirror |
| rx_fifo_bytes | input | 8*FIFO_BYTES | Receive FIFO contents to mirror |

## Verification
A wrong bridge state shows up at the ports in one of three ways. The mode byte never returns to zero, which a polling host sees within a few dozen cycles. A `reg_wr` carries the wrong address or data. Or a read request leaves a stale byte at 0x1C. A broken arbiter shows up as a host read returning something other than the byte the host just wrote, on the next cycle, while the host keeps the port busy. Mirror faults show up as stale slot bytes after one rotation of about thirty cycles.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [3:0] {
        ST_POLL,
        ST_DECODE,
        ST_RD_IDX,
        ST_LAT_IDX,
        ST_RD_VAL,
        ST_LAT_VAL,
        ST_BUS_WR,
        ST_BUS_RD,
        ST_BUS_WAIT,
        ST_PUT_VAL,
        ST_ACK,
        ST_MIRROR
    } eng_state_t;

    // Fixed mailbox slot locations inside the shared SRAM
    localparam logic [7:0] SLOT_MODE = 8'h1A;
    localparam logic [7:0] SLOT_IDX  = 8'h1B;
    localparam logic [7:0] SLOT_VAL  = 8'h1C;
    localparam logic [7:0] SLOT_IRQ  = 8'h1E;
    localparam logic [7:0] SLOT_RXST = 8'h1F;
    localparam logic [7:0] SLOT_FIFO = 8'h20;

    // Mode byte encodings
    localparam logic [7:0] REQ_IDLE = 8'h00;
    localparam logic [7:0] REQ_WR   = 8'h01;
    localparam logic [7:0] REQ_RD   = 8'h02;

endpackage

// File: rtl/mbox_sram.sv
module mbox_sram #(
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_en,
    input  logic          h_we,
    input  logic [AW-1:0] h_a,
    input  logic [7:0]    h_d,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_a,
    input  logic [7:0]    b_d,
    output logic          b_gnt,
    output logic [7:0]    q
);
    logic [7:0]    mem [DEPTH];
    logic          p_en;
    logic          p_we;
    logic [AW-1:0] p_a;
    logic [7:0]    p_d;

    // The host side always owns the port when it asks for it
    always_comb begin
        b_gnt = b_en && !h_en;
        if (h_en) begin
            p_en = 1'b1;
            p_we = h_we;
            p_a  = h_a;
            p_d  = h_d;
        end else begin
            p_en = b_en;
            p_we = b_we;
            p_a  = b_a;
            p_d  = b_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            q <= 8'h00;
        end else if (p_en) begin
            if (p_we) mem[p_a] <= p_d;
            else      q        <= mem[p_a];
        end
    end
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    input  logic [7:0]    sram_q,
    output logic          h_en,
    output logic          h_we,
    output logic [AW-1:0] h_a,
    output logic [7:0]    h_d,
    output logic [7:0]    host_rdata,
    output logic          host_rvalid
);
    logic [7:0] idx_q;
    logic [7:0] idx_snap_q;
    logic       from_sram_q;

    assign h_en = host_sel && (host_wr || host_rd);
    assign h_we = host_sel && host_wr;
    assign h_a  = idx_q[AW-1:0];
    assign h_d  = host_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= 8'h00;
            idx_snap_q  <= 8'h00;
            from_sram_q <= 1'b0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                from_sram_q <= host_sel;
                idx_snap_q  <= idx_q;
            end
            if (host_wr && !host_sel) idx_q <= host_wdata;
        end
    end

    assign host_rdata = from_sram_q ? sram_q : idx_snap_q;
endmodule

// File: rtl/mbox_mirror_sel.sv
module mbox_mirror_sel #(
    parameter int AW = 6,
    parameter int FIFO_BYTES = 8,
    localparam int MIR_N = FIFO_BYTES + 2,
    localparam int SW = $clog2(MIR_N)
) (
    input  logic [SW-1:0]           slot,
    input  logic [7:0]              irq_ident,
    input  logic [7:0]              rx_status,
    input  logic [FIFO_BYTES*8-1:0] rx_fifo_bytes,
    output logic [AW-1:0]           mir_a,
    output logic [7:0]              mir_d
);
    import mbox_pkg::*;

    logic [7:0] slot_d [MIR_N];
    logic [7:0] slot_a [MIR_N];

    assign slot_d[0] = irq_ident;
    assign slot_a[0] = SLOT_IRQ;
    assign slot_d[1] = rx_status;
    assign slot_a[1] = SLOT_RXST;

    for (genvar k = 0; k < FIFO_BYTES; k++) begin : g_fifo_slot
        assign slot_d[k+2] = rx_fifo_bytes[k*8 +: 8];
        assign slot_a[k+2] = SLOT_FIFO + 8'(k);
    end

    always_comb begin
        mir_d = slot_d[slot];
        mir_a = slot_a[slot][AW-1:0];
    end
endmodule

// File: rtl/mbox_engine.sv
module mbox_engine #(
    parameter int AW = 6,
    parameter int MIR_N = 10,
    localparam int SW = $clog2(MIR_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    sram_q,
    input  logic          b_gnt,
    output logic          b_en,
    output logic          b_we,
    output logic [AW-1:0] b_a,
    output logic [7:0]    b_d,
    output logic [SW-1:0] mir_slot,
    input  logic [AW-1:0] mir_a,
    input  logic [7:0]    mir_d,
    input  logic [7:0]    reg_rdata,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata
);
    import mbox_pkg::*;

    eng_state_t state, nxt;
    logic [7:0] mode_q;
    logic [7:0] idx_q;
    logic [7:0] val_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_POLL;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_POLL:     if (b_gnt) nxt = ST_DECODE;
            ST_DECODE:   nxt = (sram_q == REQ_WR || sram_q == REQ_RD) ? ST_RD_IDX : ST_MIRROR;
            ST_RD_IDX:   if (b_gnt) nxt = ST_LAT_IDX;
            ST_LAT_IDX:  nxt = (mode_q == REQ_WR) ? ST_RD_VAL : ST_BUS_RD;
            ST_RD_VAL:   if (b_gnt) nxt = ST_LAT_VAL;
            ST_LAT_VAL:  nxt = ST_BUS_WR;
            ST_BUS_WR:   nxt = ST_ACK;
            ST_BUS_RD:   nxt = ST_BUS_WAIT;
            ST_BUS_WAIT: nxt = ST_PUT_VAL;
            ST_PUT_VAL:  if (b_gnt) nxt = ST_ACK;
            ST_ACK:      if (b_gnt) nxt = ST_POLL;
            ST_MIRROR:   if (b_gnt) nxt = ST_POLL;
            default:     nxt = ST_POLL;
        endcase
    end

    // Outputs
    always_comb begin
        b_en   = 1'b0;
        b_we   = 1'b0;
        b_a    = SLOT_MODE[AW-1:0];
        b_d    = 8'h00;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        unique case (state)
            ST_POLL:    b_en = 1'b1;
            ST_RD_IDX:  begin b_en = 1'b1; b_a = SLOT_IDX[AW-1:0]; end
            ST_RD_VAL:  begin b_en = 1'b1; b_a = SLOT_VAL[AW-1:0]; end
            ST_PUT_VAL: begin b_en = 1'b1; b_we = 1'b1; b_a = SLOT_VAL[AW-1:0]; b_d = val_q; end
            ST_ACK:     begin b_en = 1'b1; b_we = 1'b1; b_d = REQ_IDLE; end
            ST_MIRROR:  begin b_en = 1'b1; b_we = 1'b1; b_a = mir_a; b_d = mir_d; end
            ST_BUS_WR:  reg_wr = 1'b1;
            ST_BUS_RD:  reg_rd = 1'b1;
            default:    ;
        endcase
    end

    assign reg_addr  = idx_q;
    assign reg_wdata = val_q;

    // Datapath latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= REQ_IDLE;
            idx_q    <= 8'h00;
            val_q    <= 8'h00;
            mir_slot <= '0;
        end else begin
            if (state == ST_DECODE)   mode_q <= sram_q;
            if (state == ST_LAT_IDX)  idx_q  <= sram_q;
            if (state == ST_LAT_VAL)  val_q  <= sram_q;
            if (state == ST_BUS_WAIT) val_q  <= reg_rdata;
            if (state == ST_MIRROR && b_gnt)
                mir_slot <= (mir_slot == SW'(MIR_N - 1)) ? '0 : mir_slot + 1'b1;
        end
    end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
    parameter int AW = 6,
    parameter int FIFO_BYTES = 8,
    localparam int MIR_N = FIFO_BYTES + 2,
    localparam int SW = $clog2(MIR_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic                    host_rvalid,
    output logic                    reg_wr,
    output logic                    reg_rd,
    output logic [7:0]              reg_addr,
    output logic [7:0]              reg_wdata,
    input  logic [7:0]              reg_rdata,
    input  logic [7:0]              irq_ident,
    input  logic [7:0]              rx_status,
    input  logic [FIFO_BYTES*8-1:0] rx_fifo_bytes
);
    logic          h_en, h_we, b_en, b_we, b_gnt;
    logic [AW-1:0] h_a, b_a, mir_a;
    logic [7:0]    h_d, b_d, mir_d, sram_q;
    logic [SW-1:0] mir_slot;

    mbox_host_port #(.AW(AW)) u_host (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .sram_q(sram_q),
        .h_en(h_en), .h_we(h_we), .h_a(h_a), .h_d(h_d),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    mbox_sram #(.AW(AW)) u_sram (
        .clk(clk), .rst_n(rst_n),
        .h_en(h_en), .h_we(h_we), .h_a(h_a), .h_d(h_d),
        .b_en(b_en), .b_we(b_we), .b_a(b_a), .b_d(b_d),
        .b_gnt(b_gnt), .q(sram_q)
    );

    mbox_mirror_sel #(.AW(AW), .FIFO_BYTES(FIFO_BYTES)) u_mir (
        .slot(mir_slot), .irq_ident(irq_ident), .rx_status(rx_status),
        .rx_fifo_bytes(rx_fifo_bytes), .mir_a(mir_a), .mir_d(mir_d)
    );

    mbox_engine #(.AW(AW), .MIR_N(MIR_N)) u_eng (
        .clk(clk), .rst_n(rst_n), .sram_q(sram_q), .b_gnt(b_gnt),
        .b_en(b_en), .b_we(b_we), .b_a(b_a), .b_d(b_d),
        .mir_slot(mir_slot), .mir_a(mir_a), .mir_d(mir_d),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rd,
    input logic host_rvalid,
    input logic reg_wr,
    input logic reg_rd
);
    // R1: read data is flagged valid in the cycle after a host read
    assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    // R1: no valid flag without a read one cycle earlier
    assert_no_spurious_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    // R9: the two bus strobes are mutually exclusive
    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R2: a write strobe lasts a single cycle
    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R3: a read strobe lasts a single cycle
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_rvalid(host_rvalid),
    .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/mbox_bridge_test.sv
module mbox_bridge_test;
    localparam int FB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic host_rvalid;
    logic reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata;
    logic [7:0] reg_rdata = 8'h00;
    logic [7:0] irq_ident = 8'h00, rx_status = 8'h00;
    logic [FB*8-1:0] rx_fifo_bytes = '0;

    int checks = 0, fails = 0, strobes = 0, cycles = 0;
    int exp_q[$];
    string tag_q[$];
    int wexp_q[$];
    logic [7:0] last_rd = 8'h00;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    mbox_bridge #(.AW(6), .FIFO_BYTES(FB)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ident(irq_ident), .rx_status(rx_status), .rx_fifo_bytes(rx_fifo_bytes)
    );

    // Local register model answering one cycle after a read strobe
    always @(posedge clk) if (reg_rd) reg_rdata <= model[reg_addr];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: host read results and bus write strobes
    always @(negedge clk) begin
        cycles++;
        if (host_rvalid) begin
            last_rd = host_rdata;
            if (exp_q.size() == 0) check("R1 unexpected rvalid", 1, 0);
            else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e >= 0) check(t, int'(host_rdata), e);
            end
        end
        if (reg_wr || reg_rd) strobes++;
        if (reg_wr) begin
            if (wexp_q.size() == 0) check("R2 unexpected reg_wr", 1, 0);
            else check("R2 reg_wr addr/data", int'({reg_addr, reg_wdata}), wexp_q.pop_front());
            model[reg_addr] = reg_wdata;
        end
    end

    always @(negedge clk) if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic hw(input logic sel, input logic [7:0] d);
        host_sel = sel; host_wr = 1'b1; host_rd = 1'b0; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic sel, input int exp, input string t);
        exp_q.push_back(exp); tag_q.push_back(t);
        host_sel = sel; host_rd = 1'b1; host_wr = 1'b0;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        hw(1'b0, a);
        hr(1'b1, -1, "");
        @(negedge clk);
        #0.5 v = last_rd;
    endtask

    task automatic wait_idle(input string t);
        logic [7:0] m;
        m = 8'hFF;
        for (int i = 0; i < 100 && m != 8'h00; i++) peek(8'h1A, m);
        check(t, int'(m), 0);
    endtask

    initial begin
        logic [7:0] v;
        int s0;
        for (int i = 0; i < 256; i++) model[i] = 8'((i * 3 + 1) & 255);
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 rvalid low", int'(host_rvalid), 0);
        check("R8 strobes low", int'(reg_wr | reg_rd), 0);
        rst_n = 1'b1;
        hr(1'b0, 0, "R8 index after reset");
        hw(1'b0, 8'h1A);
        hr(1'b1, 0, "R8 mode byte after reset");
        hw(1'b0, 8'h05);
        hr(1'b1, 0, "R8 sram zero after reset");

        // R1: window access
        hw(1'b1, 8'hA5);
        hr(1'b1, 8'hA5, "R1 data port readback");
        hr(1'b0, 8'h05, "R1 index port readback");
        hw(1'b0, 8'h06);
        hw(1'b1, 8'h3C);
        hr(1'b1, 8'h3C, "R1 second cell");
        hw(1'b0, 8'h05);
        hr(1'b1, 8'hA5, "R1 first cell kept");

        // R2: write request
        hw(1'b0, 8'h1B); hw(1'b1, 8'h12);
        hw(1'b0, 8'h1C); hw(1'b1, 8'h3C);
        wexp_q.push_back(int'({8'h12, 8'h3C}));
        hw(1'b0, 8'h1A); hw(1'b1, 8'h01);
        wait_idle("R2 mode cleared after write");
        check("R2 register written", int'(model[8'h12]), 8'h3C);

        // R3: read request
        hw(1'b0, 8'h1B); hw(1'b1, 8'h40);
        hw(1'b0, 8'h1A); hw(1'b1, 8'h02);
        wait_idle("R3 mode cleared after read");
        hw(1'b0, 8'h1C);
        hr(1'b1, int'(model[8'h40]), "R3 value at 0x1C");
        hw(1'b0, 8'h1B); hw(1'b1, 8'h12);
        hw(1'b0, 8'h1A); hw(1'b1, 8'h02);
        wait_idle("R3 mode cleared second read");
        hw(1'b0, 8'h1C);
        hr(1'b1, 8'h3C, "R3 read of written register");

        // R4: unsupported mode values
        s0 = strobes;
        hw(1'b0, 8'h1A); hw(1'b1, 8'h07);
        repeat (80) @(negedge clk);
        hr(1'b1, 8'h07, "R4 mode 7 unchanged");
        hw(1'b1, 8'h03);
        repeat (80) @(negedge clk);
        hr(1'b1, 8'h03, "R4 mode 3 unchanged");
        check("R4 no bus strobes", strobes - s0, 0);
        hw(1'b1, 8'h00);

        // R5 and R6: mirrors
        irq_ident = 8'h06; rx_status = 8'h85;
        for (int k = 0; k < FB; k++) rx_fifo_bytes[k*8 +: 8] = 8'(8'h90 + k);
        repeat (80) @(negedge clk);
        hw(1'b0, 8'h1E); hr(1'b1, 8'h06, "R5 interrupt mirror");
        hw(1'b0, 8'h1F); hr(1'b1, 8'h85, "R5 status mirror");
        for (int k = 0; k < FB; k++) begin
            hw(1'b0, 8'(8'h20 + k));
            hr(1'b1, 8'h90 + k, "R6 fifo mirror");
        end
        irq_ident = 8'h04;
        rx_fifo_bytes[7*8 +: 8] = 8'h5E;
        repeat (80) @(negedge clk);
        hw(1'b0, 8'h1E); hr(1'b1, 8'h04, "R5 interrupt mirror refresh");
        hw(1'b0, 8'h27); hr(1'b1, 8'h5E, "R6 last fifo byte refresh");

        // R7: host holds the port every cycle while a request is pending
        hw(1'b0, 8'h1B); hw(1'b1, 8'h22);
        hw(1'b0, 8'h1C); hw(1'b1, 8'h5A);
        wexp_q.push_back(int'({8'h22, 8'h5A}));
        hw(1'b0, 8'h1A); hw(1'b1, 8'h01);
        hw(1'b0, 8'h05);
        for (int i = 0; i < 30; i++) begin
            hw(1'b1, 8'(i * 7));
            hr(1'b1, (i * 7) & 255, "R7 host data under contention");
        end
        wait_idle("R7 request completes after contention");
        check("R7 register written", int'(model[8'h22]), 8'h5A);
        check("R2 all expected writes seen", wexp_q.size(), 0);

        repeat (4) @(negedge clk);
        check("R1 all reads returned", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule